// File: doc/BRIEF.md
# Receive Signal Detect Qualifier

This block decides whether an optical receiver has usable light. A measurement path outside the block delivers unsigned 16-bit received-power codes, one unit per 0.1 µW, at a steady rate. The block compares each code with two programmable linear thresholds. The higher one is the assert level and the lower one is the deassert level, and the space between them forms a hysteresis band. A change of state happens only after an unbroken run of qualifying samples.

The output `sig_det` is high in normal operation and low when power is below receiver sensitivity. `los_flag` is its complement and feeds a status register: it is set on loss of signal and clear otherwise. The run length `QUAL_N` is a parameter. Pick it so that `QUAL_N` times the sample period stays within the 100 µs response bound.

Samples arrive over a valid/ready stream. The block never applies back-pressure: `sample_ready` is low only while reset is held and in the first cycle after release, and high from then on. A sample counts only in a cycle where both `sample_valid` and `sample_ready` are high.

Top module: `rx_sig_detect_qual`

## Requirements
- R1: While reset is held, and after it is released, `sig_det` is 0 and `los_flag` is 1 until an assert run completes. A reset in the middle of operation returns the block to this state.
- R2: `sample_ready` is 0 during reset and becomes 1 at the first clock edge after release. It then stays 1, so the block never back-pressures.
- R3: While not detected, `sig_det` rises on the clock edge that accepts the `QUAL_N`-th consecutive accepted sample with code >= `assert_thr`. Before that edge it stays 0.
- R4: While detected, `sig_det` falls on the clock edge that accepts the `QUAL_N`-th consecutive accepted sample with code <= `deassert_thr`.
- R5: An accepted sample that does not qualify for the current state holds the state. This includes a sample strictly inside the hysteresis band.
- R6: An accepted sample that does not qualify restarts the run, so the next qualifying sample counts as the first. Cycles with `sample_valid` low neither count toward a run nor break it.
- R7: `los_flag` is always the inverse of `sig_det`: 1 means loss of signal and 0 means normal operation.
- R8: The comparisons are inclusive. A code equal to `assert_thr` qualifies for assertion, and a code equal to `deassert_thr` qualifies for deassertion.
- R9: `sig_det` changes only on a clock edge that accepts a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Power code on `sample_code` is valid |
| sample_ready | output | 1 | Block accepts a sample this cycle |
| sample_code | input | 16 | Received power, unsigned, 0.1 µW per LSB |
| assert_thr | input | 16 | Code at or above which light counts as present |
| deassert_thr | input | 16 | Code at or below which light counts as lost |
| sig_det | output | 1 | 1 = signal present, 0 = power below sensitivity |
| los_flag | output | 1 | Status copy: 1 = loss of signal, 0 = normal |

## Verification
The test drives runs of strong samples that are one short of `QUAL_N` and runs that reach it exactly. This separates the off-by-one cases of the qualification count in both directions. Runs broken by an in-band or opposite-side sample show that a broken run restarts and is not merely paused. Gaps with valid low, during which the code swings low, show that idle cycles have no effect. Samples equal to each threshold fix the inclusive comparison. A long pseudo-random stream clustered around both thresholds, with irregular valid gaps, is compared cycle by cycle against a behavioural model to catch any mismatch in band handling.

// File: rtl/rx_sig_detect_qual_pkg.sv
package rx_sig_detect_qual_pkg;
  localparam int unsigned SDQ_CODE_W = 16;

  typedef enum logic {
    SDQ_LOST    = 1'b0,
    SDQ_PRESENT = 1'b1
  } sdq_state_e;

  typedef struct packed {
    logic at_or_above_assert;
    logic at_or_below_deassert;
  } sdq_cmp_t;
endpackage

// File: rtl/sdq_level_cmp.sv
module sdq_level_cmp
  import rx_sig_detect_qual_pkg::*;
#(
  parameter int unsigned CODE_W = SDQ_CODE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] hi_thr,
  input  logic [CODE_W-1:0] lo_thr,
  input  sdq_state_e        cur_state,
  output sdq_cmp_t          cmp,
  output logic              qualifies
);
  always_comb begin
    cmp.at_or_above_assert   = (code >= hi_thr);
    cmp.at_or_below_deassert = (code <= lo_thr);
    // Only the comparison that would move the state out of its current value matters.
    qualifies = (cur_state == SDQ_LOST) ? cmp.at_or_above_assert
                                        : cmp.at_or_below_deassert;
  end
endmodule

// File: rtl/sdq_run_counter.sv
module sdq_run_counter #(
  parameter int unsigned QUAL_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic hit,
  output logic run_done
);
  localparam int unsigned CNT_W = (QUAL_N > 2) ? $clog2(QUAL_N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_N - 1);

  logic [CNT_W-1:0] run_q;

  assign run_done = accept && hit && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (accept) begin
      if (!hit || run_done) run_q <= '0;
      else                  run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdq_state_reg.sv
module sdq_state_reg
  import rx_sig_detect_qual_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flip,
  output sdq_state_e state,
  output logic       det_out,
  output logic       loss_out
);
  sdq_state_e state_q;
  logic       loss_q;

  assign state    = state_q;
  assign det_out  = (state_q == SDQ_PRESENT);
  assign loss_out = loss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SDQ_LOST;
      loss_q  <= 1'b1;
    end else if (flip) begin
      state_q <= (state_q == SDQ_LOST) ? SDQ_PRESENT : SDQ_LOST;
      loss_q  <= ~loss_q;
    end
  end
endmodule

// File: rtl/rx_sig_detect_qual.sv
module rx_sig_detect_qual
  import rx_sig_detect_qual_pkg::*;
#(
  parameter int unsigned CODE_W = SDQ_CODE_W,
  parameter int unsigned QUAL_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  output logic              sample_ready,
  input  logic [CODE_W-1:0] sample_code,
  input  logic [CODE_W-1:0] assert_thr,
  input  logic [CODE_W-1:0] deassert_thr,
  output logic              sig_det,
  output logic              los_flag
);
  logic       ready_q;
  logic       accept;
  logic       hit;
  logic       flip;
  sdq_cmp_t   cmp;
  sdq_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign sample_ready = ready_q;
  assign accept       = sample_valid && ready_q;

  sdq_level_cmp #(.CODE_W(CODE_W)) u_cmp (
    .code      (sample_code),
    .hi_thr    (assert_thr),
    .lo_thr    (deassert_thr),
    .cur_state (state),
    .cmp       (cmp),
    .qualifies (hit)
  );

  generate
    if (QUAL_N <= 1) begin : g_direct
      assign flip = accept && hit;
    end else begin : g_counted
      sdq_run_counter #(.QUAL_N(QUAL_N)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .hit      (hit),
        .run_done (flip)
      );
    end
  endgenerate

  sdq_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .flip     (flip),
    .state    (state),
    .det_out  (sig_det),
    .loss_out (los_flag)
  );
endmodule

// File: rtl/rx_sig_detect_qual_chk.sv
module rx_sig_detect_qual_chk #(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned QUAL_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              sample_ready,
  input logic [CODE_W-1:0] sample_code,
  input logic [CODE_W-1:0] assert_thr,
  input logic [CODE_W-1:0] deassert_thr,
  input logic              sig_det,
  input logic              los_flag
);
  // R7
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_det != los_flag);

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sig_det) |-> $past(sample_valid && sample_ready));

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_det) |-> $past(sample_code >= assert_thr));

  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_det) |-> $past(sample_code <= deassert_thr));

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ready |=> sample_ready);
endmodule

bind rx_sig_detect_qual rx_sig_detect_qual_chk #(.CODE_W(CODE_W), .QUAL_N(QUAL_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sample_ready (sample_ready),
  .sample_code  (sample_code),
  .assert_thr   (assert_thr),
  .deassert_thr (deassert_thr),
  .sig_det      (sig_det),
  .los_flag     (los_flag)
);

// File: tb/rx_sig_detect_qual_tb_top.sv
`timescale 1ns/1ps
module rx_sig_detect_qual_tb_top;
  localparam int QN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic        sample_ready;
  logic [15:0] sample_code = '0;
  logic [15:0] assert_thr = 16'd158;
  logic [15:0] deassert_thr = 16'd79;
  logic        sig_det;
  logic        los_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  int m_det = 0;
  int m_run = 0;
  int m_rdy = 0;

  always #4 clk = ~clk;

  rx_sig_detect_qual #(.CODE_W(16), .QUAL_N(QN)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_ready(sample_ready),
    .sample_code(sample_code), .assert_thr(assert_thr), .deassert_thr(deassert_thr),
    .sig_det(sig_det), .los_flag(los_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int hit;
    if (!rst_n) begin
      m_det = 0; m_run = 0; m_rdy = 0;
    end else begin
      if (sample_valid && m_rdy != 0) begin
        if (m_det == 0) hit = (int'(sample_code) >= int'(assert_thr)) ? 1 : 0;
        else            hit = (int'(sample_code) <= int'(deassert_thr)) ? 1 : 0;
        if (hit != 0) begin
          m_run++;
          if (m_run >= QN) begin m_det = 1 - m_det; m_run = 0; end
        end else begin
          m_run = 0;
        end
      end
      m_rdy = 1;
    end
  endtask

  // apply inputs at a falling edge, clock once, compare at the next falling edge
  task automatic step(input bit v, input int code);
    sample_valid = v;
    sample_code  = 16'(code);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R9 model sig_det", int'(sig_det), m_det);
    chk("R7 model los_flag", int'(los_flag), 1 - m_det);
    chk("R2 model ready", int'(sample_ready), m_rdy);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(0, 0);
    step(0, 0);
    rst_n = 1'b1;
    step(0, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    @(negedge clk);
    rst_n = 1'b0;
    step(0, 0);
    chk("R1 reset sig_det", int'(sig_det), 0);
    chk("R1 reset los_flag", int'(los_flag), 1);
    chk("R2 ready low in reset", int'(sample_ready), 0);
    rst_n = 1'b1;
    step(0, 0);
    chk("R2 ready after release", int'(sample_ready), 1);

    // R3: one short of the run, then complete it with idle gaps between samples
    for (int i = 0; i < QN - 1; i++) begin step(1, 300); step(0, 0); end
    chk("R3 not yet asserted", int'(sig_det), 0);
    step(1, 300);
    chk("R3 asserted on final sample", int'(sig_det), 1);
    chk("R7 loss cleared", int'(los_flag), 0);

    // R6: idle cycles with a low code do nothing
    for (int i = 0; i < 10; i++) step(0, 0);
    chk("R6 idle low code ignored", int'(sig_det), 1);

    // R5/R6: a band sample breaks the deassert run
    for (int i = 0; i < QN - 1; i++) step(1, 50);
    step(1, 100);
    chk("R5 band holds present", int'(sig_det), 1);
    for (int i = 0; i < QN - 1; i++) step(1, 50);
    chk("R6 restarted run not done", int'(sig_det), 1);
    step(1, 50);
    chk("R4 deasserted", int'(sig_det), 0);
    chk("R7 loss set", int'(los_flag), 1);

    // R5: band samples hold the lost state
    for (int i = 0; i < 3 * QN; i++) step(1, 120);
    chk("R5 band holds lost", int'(sig_det), 0);

    // R8: exactly at thresholds
    for (int i = 0; i < QN; i++) step(1, 158);
    chk("R8 equal to assert level", int'(sig_det), 1);
    for (int i = 0; i < QN; i++) step(1, 79);
    chk("R8 equal to deassert level", int'(sig_det), 0);
    for (int i = 0; i < QN; i++) step(1, 157);
    chk("R8 just under assert level", int'(sig_det), 0);

    // R1: reset in the middle of operation
    for (int i = 0; i < QN; i++) step(1, 1000);
    chk("R3 present before reset", int'(sig_det), 1);
    do_reset();
    chk("R1 reset clears detect", int'(sig_det), 0);
    chk("R1 reset sets loss", int'(los_flag), 1);

    // second threshold pair, then pseudo-random stream near both levels
    assert_thr   = 16'd400;
    deassert_thr = 16'd130;
    lfsr = 32'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      int r;
      int code;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      r = lfsr & 16'hFFFF;
      case (r % 5)
        0: code = 100 + (r % 40);
        1: code = 380 + (r % 40);
        2: code = 130;
        3: code = 400;
        default: code = r % 600;
      endcase
      step(((r >> 7) % 3) != 0, code);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule